// File: doc/BRIEF.md
# Two-Pattern Byte Matcher with a Shared Middle Section

This block watches one payload byte stream for two fixed byte strings, both given as parameters. The two strings have the same middle part. Each string is cut into three pieces: a leading piece, the middle piece and a trailing piece. Both strings use one single comparator chain for the middle piece. Each string has its own chains for its leading and trailing pieces.

Every chain is a row of one-bit states, one per character. A state sets when its own character arrives while the state before it, or the chain's enable, is high. The leading chains are always enabled, so a match can begin at any byte. The middle chain is enabled by either leading chain. A one-bit route flip-flop behaves like a JK flip-flop and records which leading chain fired. When the middle chain completes, its result goes to the trailing chain of that string only. Mixing the leading piece of one string with the trailing piece of the other therefore never reports a match.

A trailing length of zero is allowed. That string's match then comes straight from its side of the route. This covers the case where the shared part runs to the end of the string.

Top module: `shared_infix_matcher`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every chain state, the route flip-flop and both match outputs. The cycle after reset, both matches are low, and bytes received before the reset never complete a match.
- R2: When the last byte of string 1 (leading, middle and trailing pieces in that order) is accepted, `match1` is high during the clock cycle right after that edge.
- R3: When the last byte of string 2 is accepted, `match2` is high during the clock cycle right after that edge, with the same timing as R2.
- R4: The leading piece of one string followed by the middle piece and the trailing piece of the other string never raises either match. The route flip-flop behaves as follows. String 1's leading completion sets it, string 2's leading completion clears it, both together toggle it, and neither holds it. The middle chain passes its result only to the trailing chain on the side the flip-flop selects (1 = string 1).
- R5: A byte is accepted only at a rising edge where `in_valid` is high. When `in_valid` is low, no chain state and no route state changes, whatever the byte value. A string whose bytes are separated by such idle cycles still matches.
- R6: Each match is a one-cycle pulse. A match is never high in a cycle that does not directly follow an accepted byte.
- R7: A match may start at any byte position, including directly after a partial match of the same string (for example, a repeated first character).
- R8: With a trailing length of zero, the string's match pulses one cycle after the last byte of the middle piece. Only the string whose leading piece enabled that middle piece raises a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte strobe; the byte is accepted when high |
| in_byte | input | 8 | Payload byte |
| match1 | output | 1 | One-cycle pulse: string 1 complete |
| match2 | output | 1 | One-cycle pulse: string 2 complete |

## Verification
The bench builds two copies of the block. Both use the leading pieces "ab" and "cd" and the middle piece "kqz". The first copy has trailing pieces "gh" and "pq". The second copy has no trailing piece for string 2, which brings the zero-length case of R8 within reach. The letters b and d occur only at the end of the leading pieces, so the route can change only when a middle piece starts. The bench can therefore expect the result of an independent per-string suffix scan on every clock, including cross-mixed and overlapping sequences and long random streams with idle gaps.

// File: rtl/shared_infix_matcher.sv
module match_chain #(
  parameter int          LEN = 2,
  parameter logic [63:0] STR = "ab"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic [7:0] in_byte,
  input  logic       en,
  output logic       done
);
  if (LEN == 0) begin : g_empty
    wire unused_ins = ^{clk, rst, adv, in_byte};
    assign done = en;
  end else begin : g_chain
    logic [LEN-1:0] st;
    for (genvar k = 0; k < LEN; k++) begin : g_ch
      localparam logic [7:0] CH = STR[8*(LEN-1-k) +: 8];
      logic prev;
      if (k == 0) begin : g_head
        assign prev = en;
      end else begin : g_link
        assign prev = st[k-1];
      end
      always_ff @(posedge clk) begin
        if (rst)      st[k] <= 1'b0;
        else if (adv) st[k] <= prev & (in_byte == CH);
      end
    end
    assign done = st[LEN-1];

    // R7: the first state only sets when the chain was enabled
    p_stage_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(st[0]) |-> $past(en));
    // R5: idle cycles leave the chain untouched
    p_chain_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(st));
  end
endmodule

module shared_infix_matcher #(
  parameter int          PRE1_LEN  = 2,
  parameter logic [63:0] PRE1_STR  = "ab",
  parameter int          PRE2_LEN  = 2,
  parameter logic [63:0] PRE2_STR  = "cd",
  parameter int          MID_LEN   = 3,
  parameter logic [63:0] MID_STR   = "kqz",
  parameter int          POST1_LEN = 2,
  parameter logic [63:0] POST1_STR = "gh",
  parameter int          POST2_LEN = 2,
  parameter logic [63:0] POST2_STR = "pq"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       match1,
  output logic       match2
);
  logic pre1_done, pre2_done, mid_done, post1_done, post2_done;
  logic route_q, took_q, to1, to2;

  match_chain #(.LEN(PRE1_LEN), .STR(PRE1_STR)) u_pre1 (
    .clk, .rst, .adv(in_valid), .in_byte, .en(1'b1), .done(pre1_done));
  match_chain #(.LEN(PRE2_LEN), .STR(PRE2_STR)) u_pre2 (
    .clk, .rst, .adv(in_valid), .in_byte, .en(1'b1), .done(pre2_done));
  match_chain #(.LEN(MID_LEN), .STR(MID_STR)) u_mid (
    .clk, .rst, .adv(in_valid), .in_byte, .en(pre1_done | pre2_done),
    .done(mid_done));

  // JK route: J = string 1 leading done, K = string 2 leading done
  always_ff @(posedge clk) begin
    if (rst) route_q <= 1'b0;
    else if (in_valid)
      case ({pre1_done, pre2_done})
        2'b10:   route_q <= 1'b1;
        2'b01:   route_q <= 1'b0;
        2'b11:   route_q <= ~route_q;
        default: route_q <= route_q;
      endcase
  end

  assign to1 = mid_done & route_q;
  assign to2 = mid_done & ~route_q;

  match_chain #(.LEN(POST1_LEN), .STR(POST1_STR)) u_post1 (
    .clk, .rst, .adv(in_valid), .in_byte, .en(to1), .done(post1_done));
  match_chain #(.LEN(POST2_LEN), .STR(POST2_STR)) u_post2 (
    .clk, .rst, .adv(in_valid), .in_byte, .en(to2), .done(post2_done));

  always_ff @(posedge clk) begin
    if (rst) took_q <= 1'b0;
    else     took_q <= in_valid;
  end

  assign match1 = took_q & post1_done;
  assign match2 = took_q & post2_done;

  // R1: nothing reported right after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> !match1 && !match2);
  // R6: a pulse only follows an accepted byte
  p_pulse_after_byte_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !match1 && !match2);
  // R5: idle cycles keep the route
  p_route_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(route_q));
  // R4: a lone string-1 leading completion selects side 1
  p_route_set_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && pre1_done && !pre2_done |=> route_q);
  // R4: a lone string-2 leading completion selects side 2
  p_route_clr_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && pre2_done && !pre1_done |=> !route_q);
endmodule

// File: tb/shared_infix_matcher_tb.sv
`timescale 1ns/1ps
module shared_infix_matcher_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic m1, m2, e1, e2;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string req = "R1";
  string hist = "";
  bit x1 = 0, x2 = 0, xe2 = 0;
  string pat1 = "abkqzgh", pat2 = "cdkqzpq", pat2e = "cdkqz";
  string alpha = "abcdkqzghpu";

  always #2 clk = ~clk;

  shared_infix_matcher dut_i (.clk, .rst, .in_valid, .in_byte,
    .match1(m1), .match2(m2));
  shared_infix_matcher #(.POST2_LEN(0), .POST2_STR(64'h0)) dut_e (
    .clk, .rst, .in_valid, .in_byte, .match1(e1), .match2(e2));

  function automatic bit ends(string h, string p);
    if (h.len() < p.len()) return 0;
    return h.substr(h.len() - p.len(), h.len() - 1) == p;
  endfunction

  task automatic cmp(logic act, logic expv, string what);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
    end
  endtask

  task automatic step(bit r, bit v, byte b);
    @(negedge clk);
    cmp(m1, x1, "match1");
    cmp(m2, x2, "match2");
    cmp(e1, x1, "short-tail match1");
    cmp(e2, xe2, "short-tail match2");
    rst = r; in_valid = v; in_byte = b;
    x1 = 0; x2 = 0; xe2 = 0;
    if (r) hist = "";
    else if (v) begin
      hist = {hist, string'(b)};
      if (hist.len() > 16) hist = hist.substr(1, hist.len() - 1);
      x1 = ends(hist, pat1); x2 = ends(hist, pat2); xe2 = ends(hist, pat2e);
    end
  endtask

  task automatic send(string s, int gap);
    for (int i = 0; i < s.len(); i++) begin
      step(0, 1, s[i]);
      for (int g = 0; g < gap; g++) step(0, 0, "b");
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(0, 0, "z");
  endtask

  initial begin
    // R1: held in reset with bytes offered, then a stale partial match
    req = "R1";
    for (int i = 0; i < 4; i++) step(1, 1, "a");
    send("abkqz", 0);
    step(1, 1, "g");
    send("gh", 0);
    send("cdkqz", 0);
    step(1, 0, "p");
    send("pq", 0);
    idle(2);
    // R2 and R3: plain matches
    req = "R2"; send("abkqzgh", 0); idle(2);
    req = "R3"; send("cdkqzpq", 0); idle(2);
    req = "R2"; send("uuabkqzghpp", 0); idle(1);
    // R4: crossed leading and trailing pieces
    req = "R4"; send("cdkqzgh", 0); idle(2);
    send("abkqzpq", 0); idle(2);
    send("abcdkqzghcdkqzpq", 0); idle(2);
    send("cdabkqzpqabkqzgh", 0); idle(2);
    // R5: idle gaps with garbage bytes
    req = "R5"; send("abkqzgh", 2); send("cdkqzpq", 1); idle(3);
    // R6: back-to-back strings
    req = "R6"; send("abkqzghcdkqzpqabkqzgh", 0); idle(2);
    // R7: restart on repeated characters
    req = "R7"; send("aabkqzgh", 0); send("cccdkqzpq", 0); send("abkabkqzgh", 0);
    idle(2);
    // R8: zero-length trailing piece in the second copy
    req = "R8"; send("cdkqz", 0); send("abkqz", 0); send("cdkqzcdkqz", 1);
    idle(2);
    // R4 R5 R7: long random stream with injected strings
    req = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) send(pat1, 0);
      else if (r < 8) send(pat2, 0);
      else if (r < 11) send("cdkqzgh", 0);
      else if (r < 14) send("abkqzpq", 0);
      else step(0, r < 80, alpha[$urandom_range(0, alpha.len() - 1)]);
    end
    idle(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule